// File: doc/BRIEF.md
# Dirty Rectangle Queue with Bounds Check

This block gathers screen regions that need repainting. Each region is a record of four signed 32-bit values: left edge, top edge, width and height. Records enter through a valid/ready port and wait in an ordered store. A flush strobe replays them, oldest first, on a valid/ready output stream to the display-update logic. The queue is then empty.

Every record is checked as it leaves. It must be non-negative, within fixed horizontal and vertical maxima, and inside the current surface. A record that fails any test is replaced by one covering the whole surface. An invalidate strobe arms a discard: the next flush empties the queue without sending anything. When the store is full, a waiting record first causes a complete drain. The record is stored once the drain is over.

Top module: `rect_redraw_queue`

## Requirements
- R1: On a flush, the stored records leave on the output stream in the order they were accepted, one per output handshake.
- R2: While the store holds DEPTH records, in_ready is low. A record held on in_valid then starts a full drain of the store. Once the drain is over, that record is accepted and kept for the next flush.
- R3: After a drain the store is empty, so a further flush with nothing new enqueued produces no output.
- R4: An invalidate pulse causes the next flush to drop every stored record with no output. That flush clears the discard, so records enqueued afterwards are emitted normally. A flush on the same cycle as invalidate also drops.
- R5: A record with a negative x, y, w or h is emitted as x=0, y=0, w=surf_w, h=surf_h.
- R6: A record with x or w above MAX_W (2368), or y or h above MAX_H (1770), is emitted as the full-surface record (0, 0, surf_w, surf_h).
- R7: A record whose x+w exceeds surf_w or whose y+h exceeds surf_h is emitted as the full-surface record. The sums are formed one bit wider than the coordinates. Equality with the surface size passes unchanged.
- R8: While a drain is in progress, in_ready is low and flush_req has no effect.
- R9: While out_valid is high and out_ready is low, out_valid stays high and the output record does not change.
- R10: After reset, out_valid is low, in_ready is high and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Enqueue record present |
| in_ready | output | 1 | Enqueue accepted this cycle when high with in_valid |
| in_x | input | 32 | Record left edge (signed) |
| in_y | input | 32 | Record top edge (signed) |
| in_w | input | 32 | Record width (signed) |
| in_h | input | 32 | Record height (signed) |
| flush_req | input | 1 | Strobe: replay the stored records |
| invalidate | input | 1 | Strobe: the next flush discards instead of replaying |
| surf_w | input | 32 | Current surface width (unsigned) |
| surf_h | input | 32 | Current surface height (unsigned) |
| out_valid | output | 1 | Output record present |
| out_ready | input | 1 | Consumer accepts the output record |
| out_x | output | 32 | Emitted left edge |
| out_y | output | 32 | Emitted top edge |
| out_w | output | 32 | Emitted width |
| out_h | output | 32 | Emitted height |

## Verification
The bench builds the block with DEPTH=4 and keeps MAX_W and MAX_H at their defaults. With only four entries, the full-store drain path is reached after a handful of enqueues, and order can be checked across a wrap into a new batch. The surface is first set to 640x480, so that surface-edge failures and exact-fit passes are exercised. It is then raised to 4000x4000, so that the fixed maxima become the binding test rather than the surface.

// File: rtl/rrq_pkg.sv
package rrq_pkg;
  localparam int COORD_W = 32;

  typedef struct packed {
    logic signed [COORD_W-1:0] x;
    logic signed [COORD_W-1:0] y;
    logic signed [COORD_W-1:0] w;
    logic signed [COORD_W-1:0] h;
  } rect_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } drain_st_e;
endpackage

// File: rtl/rrq_store.sv
module rrq_store
  import rrq_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  rect_t                        wr_rect,
  input  logic                         clr,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx,
  output rect_t                        rd_rect,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full
);
  localparam int IW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH+1);

  rect_t            mem [DEPTH];
  logic [CNTW-1:0]  count_q, count_d;
  logic [IW-1:0]    wr_idx;

  assign wr_idx = count_q[IW-1:0];

  // next-state: clear wins over a write (writes are never requested during a clear)
  always_comb begin
    count_d = count_q;
    if (clr)
      count_d = '0;
    else if (wr_en)
      count_d = count_q + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else
      count_q <= count_d;
  end

  // storage carries no reset; only slots below count are ever read
  always_ff @(posedge clk) begin
    if (wr_en && !clr)
      mem[wr_idx] <= wr_rect;
  end

  assign rd_rect = mem[rd_idx];
  assign count   = count_q;
  assign full    = (count_q == CNTW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNTW'(DEPTH)); // R2

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en); // R2
endmodule

// File: rtl/rrq_bounds.sv
module rrq_bounds
  import rrq_pkg::*;
#(
  parameter int MAX_W = 2368,
  parameter int MAX_H = 1770
) (
  input  rect_t               rin,
  input  logic [COORD_W-1:0]  surf_w,
  input  logic [COORD_W-1:0]  surf_h,
  output rect_t               rout,
  output logic                bad
);
  localparam int SW = COORD_W + 1;
  localparam logic signed [COORD_W-1:0] LIM_W = COORD_W'(MAX_W);
  localparam logic signed [COORD_W-1:0] LIM_H = COORD_W'(MAX_H);

  logic signed [SW-1:0] span_x, span_y, edge_w, edge_h;
  logic neg_any, over_max, over_surf;

  // one extra bit keeps the edge sums exact
  assign span_x = $signed({rin.x[COORD_W-1], rin.x}) + $signed({rin.w[COORD_W-1], rin.w});
  assign span_y = $signed({rin.y[COORD_W-1], rin.y}) + $signed({rin.h[COORD_W-1], rin.h});
  assign edge_w = $signed({1'b0, surf_w});
  assign edge_h = $signed({1'b0, surf_h});

  assign neg_any   = rin.x[COORD_W-1] | rin.y[COORD_W-1] | rin.w[COORD_W-1] | rin.h[COORD_W-1];
  assign over_max  = (rin.x > LIM_W) | (rin.w > LIM_W) | (rin.y > LIM_H) | (rin.h > LIM_H);
  assign over_surf = (span_x > edge_w) | (span_y > edge_h);
  assign bad       = neg_any | over_max | over_surf;

  always_comb begin
    rout = rin;
    if (bad) begin
      rout.x = '0;
      rout.y = '0;
      rout.w = $signed(surf_w);
      rout.h = $signed(surf_h);
    end
  end
endmodule

// File: rtl/rrq_ctrl.sv
module rrq_ctrl
  import rrq_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_req,
  input  logic                         invalidate,
  input  logic                         in_valid,
  input  logic                         out_ready,
  input  logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic                         full,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic                         clr,
  output logic [$clog2(DEPTH)-1:0]     rd_idx
);
  localparam int IW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH+1);

  drain_st_e       st_q, st_d;
  logic [IW-1:0]   rd_q, rd_d;
  logic            drop_q, drop_d;
  logic            drop_now, start_req, last_out;

  assign drop_now  = drop_q | invalidate;
  assign start_req = flush_req | (in_valid & full);
  assign last_out  = (CNTW'(rd_q) + CNTW'(1)) == count;

  always_comb begin
    st_d   = st_q;
    rd_d   = rd_q;
    drop_d = drop_q | invalidate;
    clr    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          if (drop_now) begin
            clr    = 1'b1;
            drop_d = 1'b0;
          end else if (count != '0) begin
            st_d = ST_DRAIN;
            rd_d = '0;
          end
        end
      end
      ST_DRAIN: begin
        if (out_ready) begin
          if (last_out) begin
            clr  = 1'b1;
            st_d = ST_IDLE;
            rd_d = '0;
          end else begin
            rd_d = rd_q + IW'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rd_q   <= '0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rd_q   <= rd_d;
      drop_q <= drop_d;
    end
  end

  assign out_valid = (st_q == ST_DRAIN);
  assign in_ready  = (st_q == ST_IDLE) & ~full & ~flush_req;
  assign rd_idx    = rd_q;

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && flush_req && drop_now) |=> (!out_valid && count == '0)); // R4

  AST_DRAIN_ENDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (count == '0)); // R3

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (CNTW'(rd_q) < count)); // R1
endmodule

// File: rtl/rect_redraw_queue.sv
module rect_redraw_queue
  import rrq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int MAX_W = 2368,
  parameter int MAX_H = 1770
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_x,
  input  logic [31:0]        in_y,
  input  logic [31:0]        in_w,
  input  logic [31:0]        in_h,
  input  logic               flush_req,
  input  logic               invalidate,
  input  logic [31:0]        surf_w,
  input  logic [31:0]        surf_h,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_x,
  output logic [31:0]        out_y,
  output logic [31:0]        out_w,
  output logic [31:0]        out_h
);
  localparam int IW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH+1);

  // asynchronous assertion, synchronous release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  rect_t            wr_rect, rd_rect, chk_rect;
  logic             clr, full, wr_en, fail_unused;
  logic [IW-1:0]    rd_idx;
  logic [CNTW-1:0]  count;

  assign wr_rect = '{x: $signed(in_x), y: $signed(in_y), w: $signed(in_w), h: $signed(in_h)};
  assign wr_en   = in_valid & in_ready;

  rrq_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_s2),
    .wr_en   (wr_en),
    .wr_rect (wr_rect),
    .clr     (clr),
    .rd_idx  (rd_idx),
    .rd_rect (rd_rect),
    .count   (count),
    .full    (full)
  );

  rrq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s2),
    .flush_req  (flush_req),
    .invalidate (invalidate),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .count      (count),
    .full       (full),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .clr        (clr),
    .rd_idx     (rd_idx)
  );

  rrq_bounds #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_bounds (
    .rin    (rd_rect),
    .surf_w (surf_w),
    .surf_h (surf_h),
    .rout   (chk_rect),
    .bad    (fail_unused)
  );

  assign out_x = chk_rect.x;
  assign out_y = chk_rect.y;
  assign out_w = chk_rect.w;
  assign out_h = chk_rect.h;

  AST_NO_ENQ_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_s2)
    out_valid |-> !in_ready); // R8

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_s2)
    (out_valid && !out_ready) |=> out_valid); // R9

  AST_OUT_NONNEG: assert property (@(posedge clk) disable iff (!rst_s2)
    out_valid |-> !(out_x[31] | out_y[31] | out_w[31] | out_h[31])); // R5

  AST_OUT_INSIDE: assert property (@(posedge clk) disable iff (!rst_s2)
    out_valid |-> (({1'b0, out_x} + {1'b0, out_w}) <= {1'b0, surf_w} &&
                   ({1'b0, out_y} + {1'b0, out_h}) <= {1'b0, surf_h})); // R7
endmodule

// File: tb/rect_redraw_queue_tb.sv
module rect_redraw_queue_tb;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, flush_req = 1'b0, invalidate = 1'b0, out_ready = 1'b1;
  logic [31:0] in_x = '0, in_y = '0, in_w = '0, in_h = '0;
  logic [31:0] surf_w = 32'd640, surf_h = 32'd480;
  logic in_ready, out_valid;
  logic [31:0] out_x, out_y, out_w, out_h;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rect_redraw_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_w(in_w), .in_h(in_h),
    .flush_req(flush_req), .invalidate(invalidate),
    .surf_w(surf_w), .surf_h(surf_h),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_w(out_w), .out_h(out_h)
  );

  // {in x, y, w, h, expected x, y, w, h}, surface 640x480
  localparam logic [255:0] VEC [8] = '{
    {32'd10, 32'd20, 32'd100, 32'd50,   32'd10, 32'd20, 32'd100, 32'd50},
    {32'hFFFFFFFF, 32'd0, 32'd10, 32'd10, 32'd0, 32'd0, 32'd640, 32'd480},
    {32'd0, 32'd0, 32'd640, 32'd480,    32'd0, 32'd0, 32'd640, 32'd480},
    {32'd1, 32'd0, 32'd640, 32'd10,     32'd0, 32'd0, 32'd640, 32'd480},
    {32'd0, 32'd1771, 32'd1, 32'd1,     32'd0, 32'd0, 32'd640, 32'd480},
    {32'd5, 32'd5, 32'd0, 32'd0,        32'd5, 32'd5, 32'd0, 32'd0},
    {32'd0, 32'd479, 32'd10, 32'd1,     32'd0, 32'd479, 32'd10, 32'd1},
    {32'd0, 32'd479, 32'd10, 32'd2,     32'd0, 32'd0, 32'd640, 32'd480}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [127:0] r);
    {in_x, in_y, in_w, in_h} = r;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_flush();
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  task automatic expect_rect(input string tag, input logic [127:0] exp);
    int waited = 0;
    while (!out_valid && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    check({tag, " valid"}, {127'd0, out_valid}, 128'd1);
    check({tag, " rect"}, {out_x, out_y, out_w, out_h}, exp);
    check("R8 in_ready low in drain", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
  endtask

  task automatic expect_quiet(input string tag, input int n);
    logic seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (out_valid) seen = 1'b1;
      @(negedge clk);
    end
    check(tag, {127'd0, seen}, 128'd0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10 out_valid", {127'd0, out_valid}, 128'd0);
    check("R10 in_ready", {127'd0, in_ready}, 128'd1);
    pulse_flush();
    expect_quiet("R10 empty store", 5);

    // R1 R5 R6 R7: table walk in batches of DEPTH
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 4; i++) push(VEC[b*4+i][255:128]);
      pulse_flush();
      for (int i = 0; i < 4; i++) expect_rect("R1 R5 R6 R7 table", VEC[b*4+i][127:0]);
    end
    // R3: nothing left after drain
    pulse_flush();
    expect_quiet("R3 second flush silent", 6);

    // R6: maxima binding on a big surface
    surf_w = 32'd4000; surf_h = 32'd4000;
    push({32'd0, 32'd0, 32'd2369, 32'd1});
    push({32'd0, 32'd0, 32'd2368, 32'd1770});
    push({32'd2369, 32'd0, 32'd0, 32'd0});
    push({32'd0, 32'd0, 32'd1, 32'd1771});
    pulse_flush();
    expect_rect("R6 w over max", {32'd0, 32'd0, 32'd4000, 32'd4000});
    expect_rect("R6 at max", {32'd0, 32'd0, 32'd2368, 32'd1770});
    expect_rect("R6 x over max", {32'd0, 32'd0, 32'd4000, 32'd4000});
    expect_rect("R6 h over max", {32'd0, 32'd0, 32'd4000, 32'd4000});
    surf_w = 32'd640; surf_h = 32'd480;

    // R2: full store drains before taking the new record
    for (int i = 0; i < 4; i++) push({32'(i), 32'd1, 32'd2, 32'd3});
    check("R2 in_ready low when full", {127'd0, in_ready}, 128'd0);
    fork
      push({32'd9, 32'd9, 32'd9, 32'd9});
      begin
        for (int i = 0; i < 4; i++) expect_rect("R2 auto drain", {32'(i), 32'd1, 32'd2, 32'd3});
      end
    join
    pulse_flush();
    expect_rect("R2 held record kept", {32'd9, 32'd9, 32'd9, 32'd9});
    expect_quiet("R2 only one left", 5);

    // R4: invalidate discards, then clears
    push({32'd1, 32'd1, 32'd1, 32'd1});
    push({32'd2, 32'd2, 32'd2, 32'd2});
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    pulse_flush();
    expect_quiet("R4 dropped", 6);
    push({32'd3, 32'd3, 32'd3, 32'd3});
    pulse_flush();
    expect_rect("R4 after discard", {32'd3, 32'd3, 32'd3, 32'd3});
    // R4: invalidate and flush together
    push({32'd4, 32'd4, 32'd4, 32'd4});
    invalidate = 1'b1;
    pulse_flush();
    invalidate = 1'b0;
    expect_quiet("R4 same-cycle drop", 6);

    // R9 R8: stall hold and flush ignored mid-drain
    push({32'd7, 32'd8, 32'd9, 32'd10});
    push({32'd11, 32'd12, 32'd13, 32'd14});
    out_ready = 1'b0;
    pulse_flush();
    for (int k = 0; k < 3; k++) begin
      check("R9 held valid", {127'd0, out_valid}, 128'd1);
      check("R9 held rect", {out_x, out_y, out_w, out_h}, {32'd7, 32'd8, 32'd9, 32'd10});
      if (k == 1) flush_req = 1'b1;
      @(negedge clk);
      flush_req = 1'b0;
    end
    out_ready = 1'b1;
    expect_rect("R9 first", {32'd7, 32'd8, 32'd9, 32'd10});
    expect_rect("R8 second", {32'd11, 32'd12, 32'd13, 32'd14});
    expect_quiet("R8 extra flush ignored", 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule